// File: doc/BRIEF.md
# Pipelined Four-Lane Frame Summer

This block adds up frames of eight signed 32-bit words and produces one total for each frame. A frame arrives as two beats of four words each. The first beat is marked by a start flag, and the second beat follows it. All four words of a beat are captured in the same clock edge. They are then reduced by a balanced adder tree of registered levels: the pairwise sums come first, then the final sum. A fold stage holds the partial sum of the opening beat. When the closing beat's partial sum arrives, the fold stage adds it in and emits the frame total with a one-cycle valid strobe.

A new beat can be accepted on every clock, and the next frame may start on the cycle right after the previous frame closes. Under continuous input the block therefore delivers one total every two cycles. The depth of the adder tree changes only the delay to the first result, not this rate. The tree depth comes from the lane count, and the flags of each beat travel with its data through every stage.

Top module: `quad_frame_summer`

## Requirements
- R1: For a frame made of an opening beat (in_valid=1, in_first=1) and a closing beat (in_valid=1, in_first=0), out_sum equals the sum of all eight words. Lane k sits in bits [32k+31:32k] of in_lanes.
- R2: If the closing beat is sampled at rising edge n, out_valid and out_sum appear after edge n+3 and hold for one cycle.
- R3: Frames fed back to back, with no idle cycle, produce one total every two cycles, and each total belongs to its own frame.
- R4: out_valid is high for exactly one cycle per completed frame and is never high on two consecutive cycles.
- R5: An opening beat always starts a new frame. If it arrives while an earlier opening beat is still waiting, the earlier partial sum is discarded.
- R6: A closing beat that arrives with no opening beat waiting produces no output and has no effect.
- R7: Cycles with in_valid=0 are ignored whatever the values on in_lanes and in_first. Such idle cycles may fall between the two beats of a frame without changing the total.
- R8: Synchronous active-high rst clears every pipeline valid bit, the waiting-frame state and out_valid. A closing beat sent right after reset produces no output.
- R9: Arithmetic wraps modulo 2^32 in two's complement. Eight words of 0x7FFFFFFF give 0xFFFFFFF8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat is present on in_lanes |
| in_first | input | 1 | The beat opens a frame (0 = closing beat) |
| in_lanes | input | 128 | Four 32-bit words, lane k at bits [32k+31:32k] |
| out_valid | output | 1 | One-cycle strobe for a frame total |
| out_sum | output | 32 | Frame total, modulo 2^32 |

## Verification
The bound checker watches several things on every cycle. It checks that the beat flags emerge from the tree exactly two edges after capture, and that a strobe is never followed by another strobe. It checks that every strobe is preceded by a closing beat meeting a waiting opening beat, that an opening beat arms the fold stage without producing output, and that reset leaves neither a strobe nor a waiting frame. The numeric totals are shown only by the bench's scenarios: a sweep of opening/closing value patterns fed back to back, overflow words, idle gaps inside a frame, orphan closing beats, a repeated opening beat and a reset in mid-frame. In each case the bench compares the output on every cycle against a schedule computed from the requirements.

// File: rtl/qfs_pkg.sv
`timescale 1ns/1ps
package qfs_pkg;
  // Tag carried beside each beat's data through every stage.
  typedef struct packed {
    logic valid;
    logic first;
  } beat_tag_t;
endpackage

// File: rtl/qfs_capture.sv
`timescale 1ns/1ps
module qfs_capture
  import qfs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic                    first_i,
  input  logic [LANES*DATA_W-1:0] lanes_i,
  output beat_tag_t               tag_o,
  output logic [LANES*DATA_W-1:0] lanes_o
);
  beat_tag_t               tag_q;
  logic [LANES*DATA_W-1:0] lanes_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else begin
      tag_q.valid <= valid_i;
      tag_q.first <= valid_i & first_i;
    end
  end

  // Data is only loaded on a valid beat; idle cycles leave it unchanged.
  always_ff @(posedge clk) begin
    if (valid_i) lanes_q <= lanes_i;
  end

  assign tag_o   = tag_q;
  assign lanes_o = lanes_q;
endmodule

// File: rtl/qfs_tree.sv
`timescale 1ns/1ps
module qfs_tree
  import qfs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  beat_tag_t               tag_i,
  input  logic [LANES*DATA_W-1:0] lanes_i,
  output beat_tag_t               tag_o,
  output logic [DATA_W-1:0]       sum_o
);
  localparam int LEVELS = $clog2(LANES);

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int N = LANES >> (l + 1);
    logic [2*N*DATA_W-1:0] src;
    beat_tag_t             src_tag;
    logic [N*DATA_W-1:0]   sum_q;
    beat_tag_t             tag_q;

    if (l == 0) begin : g_head
      assign src     = lanes_i;
      assign src_tag = tag_i;
    end else begin : g_next
      assign src     = g_lvl[l-1].sum_q;
      assign src_tag = g_lvl[l-1].tag_q;
    end

    always_ff @(posedge clk) begin
      if (rst) tag_q <= '0;
      else     tag_q <= src_tag;
    end

    always_ff @(posedge clk) begin
      for (int j = 0; j < N; j++) begin
        sum_q[j*DATA_W +: DATA_W] <= wrap_add(src[(2*j)*DATA_W +: DATA_W],
                                              src[(2*j+1)*DATA_W +: DATA_W]);
      end
    end
  end

  assign sum_o = g_lvl[LEVELS-1].sum_q;
  assign tag_o = g_lvl[LEVELS-1].tag_q;
endmodule

// File: rtl/qfs_fold.sv
`timescale 1ns/1ps
module qfs_fold
  import qfs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  beat_tag_t         tag_i,
  input  logic [DATA_W-1:0] sum_i,
  output logic              pending_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] total_o
);
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic              pend_q;
  logic [DATA_W-1:0] acc_q;
  logic              vld_q;
  logic [DATA_W-1:0] tot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
      tot_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      if (tag_i.valid) begin
        if (tag_i.first) begin
          // Opening beat loads the accumulator directly; no stale carry-over.
          acc_q  <= sum_i;
          pend_q <= 1'b1;
        end else if (pend_q) begin
          tot_q  <= wrap_add(acc_q, sum_i);
          vld_q  <= 1'b1;
          pend_q <= 1'b0;
          acc_q  <= '0;
        end
      end
    end
  end

  assign pending_o = pend_q;
  assign valid_o   = vld_q;
  assign total_o   = tot_q;
endmodule

// File: rtl/quad_frame_summer.sv
`timescale 1ns/1ps
module quad_frame_summer
  import qfs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_first,
  input  logic [LANES*DATA_W-1:0] in_lanes,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_sum
);
  beat_tag_t               cap_tag;
  logic [LANES*DATA_W-1:0] cap_lanes;
  beat_tag_t               tree_tag;
  logic [DATA_W-1:0]       tree_sum;

  // Named event wires for the bound checker.
  logic cap_valid;
  logic tree_valid;
  logic tree_first;
  logic fold_pending;

  qfs_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .first_i (in_first),
    .lanes_i (in_lanes),
    .tag_o   (cap_tag),
    .lanes_o (cap_lanes)
  );

  qfs_tree #(.DATA_W(DATA_W), .LANES(LANES)) u_tree (
    .clk     (clk),
    .rst     (rst),
    .tag_i   (cap_tag),
    .lanes_i (cap_lanes),
    .tag_o   (tree_tag),
    .sum_o   (tree_sum)
  );

  qfs_fold #(.DATA_W(DATA_W)) u_fold (
    .clk       (clk),
    .rst       (rst),
    .tag_i     (tree_tag),
    .sum_i     (tree_sum),
    .pending_o (fold_pending),
    .valid_o   (out_valid),
    .total_o   (out_sum)
  );

  assign cap_valid  = cap_tag.valid;
  assign tree_valid = tree_tag.valid;
  assign tree_first = tree_tag.first;
endmodule

// File: rtl/quad_frame_summer_chk.sv
`timescale 1ns/1ps
module quad_frame_summer_chk (
  input logic clk,
  input logic rst,
  input logic cap_valid,
  input logic tree_valid,
  input logic tree_first,
  input logic fold_pending,
  input logic out_valid
);
  // Beat flags leave the two-level tree two edges after capture.
  assert_tag_latency_R2: assert property (@(posedge clk) disable iff (rst)
    cap_valid |=> ##1 tree_valid);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_first_arms_R5: assert property (@(posedge clk) disable iff (rst)
    (tree_valid && tree_first) |=> (fold_pending && !out_valid));

  assert_result_needs_pair_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tree_valid && !tree_first && fold_pending));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !fold_pending));
endmodule

bind quad_frame_summer quad_frame_summer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cap_valid    (cap_valid),
  .tree_valid   (tree_valid),
  .tree_first   (tree_first),
  .fold_pending (fold_pending),
  .out_valid    (out_valid)
);

// File: tb/quad_frame_summer_test.sv
`timescale 1ns/1ps
module quad_frame_summer_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_first = 1'b0;
  logic [127:0] in_lanes = '0;
  logic         out_valid;
  logic [31:0]  out_sum;

  quad_frame_summer uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_lanes  (in_lanes),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    pulses = 0;
  bit    done = 1'b0;
  bit    exp_v [16];
  logic [31:0] exp_d [16];
  string exp_tag [16];
  string quiet_tag = "R8";
  bit    pend = 1'b0;
  longint part = 0;
  logic [31:0] vals [8];

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Per-cycle monitor: compares outputs against the bench's schedule.
  always @(negedge clk) begin
    if (!rst) begin
      int idx;
      idx = cyc % 16;
      if (out_valid) pulses++;
      if (exp_v[idx]) begin
        check(out_valid === 1'b1, exp_tag[idx], "out_valid", {31'd0, out_valid}, 32'd1);
        check(out_sum === exp_d[idx], exp_tag[idx], "out_sum", out_sum, exp_d[idx]);
      end else begin
        check(out_valid === 1'b0, quiet_tag, "unexpected out_valid", {31'd0, out_valid}, 32'd0);
      end
      exp_v[idx] = 1'b0;
    end
  end

  function automatic longint lane_total(logic [31:0] a, logic [31:0] b,
                                        logic [31:0] c, logic [31:0] d);
    return longint'($signed(a)) + longint'($signed(b)) + longint'($signed(c)) + longint'($signed(d));
  endfunction

  task automatic beat(bit v, bit f, logic [31:0] a, logic [31:0] b,
                      logic [31:0] c, logic [31:0] d, string tag);
    @(negedge clk);
    in_valid = v;
    in_first = f;
    in_lanes = {d, c, b, a};
    if (v) begin
      if (f) begin
        pend = 1'b1;
        part = lane_total(a, b, c, d);
      end else if (pend) begin
        int slot;
        longint tot;
        slot = (cyc + 4) % 16;
        tot  = part + lane_total(a, b, c, d);
        exp_v[slot]   = 1'b1;
        exp_d[slot]   = tot[31:0];
        exp_tag[slot] = tag;
        pend = 1'b0;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = (i % 2 == 0);
      in_lanes = {4{32'hDEAD_0000 + 32'(i)}};
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R8", "out_valid during reset", {31'd0, out_valid}, 32'd0);
    for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;
    pend = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
             32'h8000_0000, 32'd3, 32'hFFFF_FFFB, 32'd12345678};
    for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    idle(4);

    // R1/R3: sweep of opening x closing patterns, back to back.
    quiet_tag = "R3";
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        beat(1, 1, vals[i], vals[(i+1)%8], vals[(i+2)%8], vals[(i+3)%8], "R1");
        beat(1, 0, vals[j], vals[(j+2)%8], vals[(j+4)%8], vals[(j+6)%8], "R3");
      end
    end
    idle(6);
    check(pulses == 64, "R3", "frame count", 32'(pulses), 32'd64);

    // R9: overflow wraps.
    quiet_tag = "R9";
    beat(1, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9");
    beat(1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9");
    idle(6);
    beat(1, 1, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, "R9");
    beat(1, 0, 32'h8000_0000, 32'd5, 32'd7, 32'hFFFF_FFFE, "R9");
    idle(6);

    // R7: idle gaps with noise between the two beats.
    quiet_tag = "R7";
    for (int g = 1; g < 4; g++) begin
      beat(1, 1, 32'(g), 32'(10*g), 32'(100*g), 32'hFFFF_0000, "R7");
      idle(g);
      beat(1, 0, 32'd9, 32'(g*7), 32'hFFFF_FFF0, 32'(1000*g), "R7");
      idle(6);
    end

    // R6: orphan closing beats produce nothing, then a normal frame.
    quiet_tag = "R6";
    beat(1, 0, 32'd11, 32'd22, 32'd33, 32'd44, "R6");
    beat(1, 0, 32'd55, 32'd66, 32'd77, 32'd88, "R6");
    idle(6);
    beat(1, 1, 32'd1, 32'd2, 32'd3, 32'd4, "R6");
    beat(1, 0, 32'd5, 32'd6, 32'd7, 32'd8, "R6");
    beat(1, 0, 32'd100, 32'd100, 32'd100, 32'd100, "R6");
    idle(6);

    // R5: a second opening beat replaces the first.
    quiet_tag = "R5";
    beat(1, 1, 32'd1000, 32'd1000, 32'd1000, 32'd1000, "R5");
    beat(1, 1, 32'd1, 32'd1, 32'd1, 32'd1, "R5");
    beat(1, 0, 32'd2, 32'd2, 32'd2, 32'd2, "R5");
    idle(6);

    // R4: single pulse per frame under alternating gaps.
    quiet_tag = "R4";
    for (int k = 0; k < 6; k++) begin
      beat(1, 1, 32'(k), 32'(k+1), 32'(k+2), 32'(k+3), "R4");
      beat(1, 0, 32'(k*k), 32'd0, 32'hFFFF_FFFF, 32'(k), "R4");
      if (k % 2 == 1) idle(1);
    end
    idle(6);

    // R8: reset mid-frame, then a closing beat must be ignored.
    quiet_tag = "R8";
    beat(1, 1, 32'd9, 32'd9, 32'd9, 32'd9, "R8");
    do_reset();
    beat(1, 0, 32'd1, 32'd1, 32'd1, 32'd1, "R8");
    idle(6);
    beat(1, 1, 32'd3, 32'd3, 32'd3, 32'd3, "R8");
    beat(1, 0, 32'd4, 32'd4, 32'd4, 32'd4, "R8");
    idle(8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule